// File: doc/BRIEF.md
# Horizontal Sync Phase Detector

This block compares the rising edge of an incoming horizontal sync pulse with the rising edge of a feedback pulse. The feedback pulse comes from dividing the regenerated pixel clock. The block turns the timing difference into pump-up and pump-down enables for an external charge pump. It also gives a drive flag that is low whenever the pump is to float in high impedance. The block runs on a sampling clock much faster than the line rate. Both pulse inputs are asynchronous to it and are resynchronised on entry.

A two-bit mode input selects one of three loop behaviours:
- **Normal tracking:** pump pulses are exactly as wide as the edge offset.
- **Fast-lock:** each pulse is stretched to raise the effective loop gain.
- **Coast:** the pump floats, so the loop rides through disturbed reference timing such as tape head switching.

A lock qualifier counts consecutive lines whose edge offset falls inside a programmable window. The lock output stays low while the loop is locked. It pulses high once for every comparison made while the loop is not locked.

Top module: `hsync_phase_det`

## Requirements
- R1: The mode code is decoded as follows: 2'b00 is normal tracking, 2'b01 is fast-lock, and 2'b10 or 2'b11 is coast.
- R2: Only rising edges count as events, and each input passes two synchroniser flops. A rising edge first sampled on clock edge k makes pump activity visible after clock edge k+2.
- R3: When the sync edge leads the feedback edge by d sample clocks, pumpUp is high for exactly d consecutive cycles in normal mode, and pumpDown stays low.
- R4: When the feedback edge leads the sync edge by d sample clocks, pumpDown is high for exactly d cycles in normal mode, and pumpUp stays low.
- R5: Edges that arrive in the same sample cycle give zero error, and both pump enables stay low.
- R6: A second sync edge that arrives before the feedback edge leaves pumpUp asserted. Only the feedback edge ends the comparison, so a higher sync rate drives the frequency up.
- R7: pumpDrive is high exactly when one of pumpUp or pumpDown is high, and the two enables are never high together. All outputs are low in reset.
- R8: In fast-lock, a comparison with offset d gives one continuous pump pulse of 4*d cycles in the direction of the leading edge.
- R9: In coast, both pump enables and pumpDrive stay low and no lock pulse appears. The lock count and the lock state are kept unchanged, so they still hold when coast ends.
- R10: A comparison whose offset is at most lockWindow counts as a good line. After 8 consecutive good lines the loop is locked. lockOut goes high for one cycle, directly after the comparison ends, for every comparison outside coast that leaves the loop unlocked.
- R11: A single comparison with an offset above lockWindow clears the lock count at once. The lock is lost, and a pulse is given on that same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Horizontal sync reference pulse (asynchronous) |
| fbIn | input | 1 | Divided pixel-clock feedback pulse (asynchronous) |
| mode | input | 2 | Loop mode code (see R1) |
| lockWindow | input | OFS_W (12) | Largest edge offset, in sample clocks, that counts as a good line |
| pumpUp | output | 1 | Enable current into the loop filter (raise frequency) |
| pumpDown | output | 1 | Enable current out of the loop filter (lower frequency) |
| pumpDrive | output | 1 | High while the pump drives; low means high impedance |
| lockOut | output | 1 | Low while locked; one-cycle high pulse per unlocked comparison |

## Verification
The bench targets four corner cases:
- Edges that coincide. A detector that mishandles them leaves a one-cycle pump pulse where none is due.
- A repeated sync edge with no feedback edge between. A faulty clear would cut the up pulse short at the second edge.
- Fast-lock stretching. A wrong stretch shows up as a pulse that is not 4*d long, or one that breaks in two.
- The lock counter around coast and around a line outside the window. Bugs there show as lock pulses during coast, a lock lost after coast, or a count that still holds after a bad line.

The first pump cycle after a sync edge is also timed, which catches a missing or extra synchroniser stage.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

  typedef enum logic [1:0] {
    MODE_TRACK   = 2'b00,
    MODE_FAST    = 2'b01,
    MODE_COAST   = 2'b10,
    MODE_COAST_H = 2'b11
  } loopModeE;

  // strobes from control to datapath
  typedef struct packed {
    logic upHeld;
    logic dnHeld;
    logic cmpDone;
    logic coast;
    logic fast;
  } ctrlStrobeT;

endpackage

// File: rtl/hpd_sync_edge.sv
module hpd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  // STAGES synchroniser flops plus one history flop for the edge
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/hpd_ctrl.sv
module hpd_ctrl
  import hpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       fbIn,
  input  logic [1:0] mode,
  output ctrlStrobeT strobe
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] evt;
  logic upQ, dnQ, done;
  loopModeE modeDec;

  assign rawIn = {fbIn, syncIn};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_edge
    hpd_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk (clk),
      .rstN(rstN),
      .din (rawIn[g]),
      .rise(evt[g])
    );
  end

  // the comparison ends once both edges have been seen
  assign done = (upQ | evt[0]) & (dnQ | evt[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (done) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upQ | evt[0];
      dnQ <= dnQ | evt[1];
    end
  end

  assign modeDec = loopModeE'(mode);

  always_comb begin
    strobe.upHeld  = upQ;
    strobe.dnHeld  = dnQ;
    strobe.cmpDone = done;
    strobe.coast   = (modeDec == MODE_COAST) || (modeDec == MODE_COAST_H);
    strobe.fast    = (modeDec == MODE_FAST);
  end
endmodule

// File: rtl/hpd_datapath.sv
module hpd_datapath
  import hpd_pkg::*;
#(
  parameter int OFS_W      = 12,
  parameter int LOCK_LINES = 8,
  parameter int STRETCH    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [OFS_W-1:0] lockWindow,
  output logic             pumpUp,
  output logic             pumpDown,
  output logic             pumpDrive,
  output logic             lockOut
);
  localparam int CNT_W = $clog2(LOCK_LINES + 1);
  localparam int STR_W = OFS_W + $clog2(STRETCH) + 1;
  localparam logic [CNT_W-1:0] LOCK_FULL = CNT_W'(LOCK_LINES);
  localparam logic [STR_W-1:0] STR_MULT  = STR_W'(STRETCH - 1);

  logic             held;
  logic [OFS_W-1:0] ofsCnt;
  logic [OFS_W:0]   ofsSum;
  logic [OFS_W-1:0] offsetNow;
  logic [STR_W-1:0] strCnt;
  logic             strDirUp;
  logic [CNT_W-1:0] goodCnt;
  logic [CNT_W-1:0] goodNext;
  logic             inWindow;
  logic             evalNow;
  logic             rawAct;
  logic             strAct;

  assign held      = strobe.upHeld | strobe.dnHeld;
  assign ofsSum    = {1'b0, ofsCnt} + {{OFS_W{1'b0}}, held};
  assign offsetNow = ofsSum[OFS_W] ? {OFS_W{1'b1}} : ofsSum[OFS_W-1:0];

  // offset in sample clocks between the two edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     ofsCnt <= '0;
    else if (strobe.cmpDone)       ofsCnt <= '0;
    else if (held)                 ofsCnt <= offsetNow;
    else                           ofsCnt <= '0;
  end

  // fast-lock pulse extension
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strCnt   <= '0;
      strDirUp <= 1'b0;
    end else if (strobe.coast || !strobe.fast) begin
      strCnt   <= '0;
    end else if (strobe.cmpDone) begin
      strCnt   <= STR_MULT * STR_W'(offsetNow);
      strDirUp <= strobe.upHeld;
    end else if (strCnt != '0) begin
      strCnt   <= strCnt - 1'b1;
    end
  end

  // lock qualifier
  assign evalNow  = strobe.cmpDone & ~strobe.coast;
  assign inWindow = (offsetNow <= lockWindow);

  always_comb begin
    if (!inWindow)                goodNext = '0;
    else if (goodCnt == LOCK_FULL) goodNext = goodCnt;
    else                          goodNext = goodCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
      lockOut <= 1'b0;
    end else if (evalNow) begin
      goodCnt <= goodNext;
      lockOut <= (goodNext != LOCK_FULL);
    end else begin
      lockOut <= 1'b0;
    end
  end

  // pump enables: raw comparison wins over an extension in progress
  assign rawAct    = held;
  assign strAct    = strobe.fast & (strCnt != '0) & ~rawAct;
  assign pumpUp    = ~strobe.coast & (strobe.upHeld | (strAct & strDirUp));
  assign pumpDown  = ~strobe.coast & (strobe.dnHeld | (strAct & ~strDirUp));
  assign pumpDrive = pumpUp | pumpDown;
endmodule

// File: rtl/hsync_phase_det.sv
module hsync_phase_det
  import hpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OFS_W       = 12,
  parameter int LOCK_LINES  = 8,
  parameter int STRETCH     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             fbIn,
  input  logic [1:0]       mode,
  input  logic [OFS_W-1:0] lockWindow,
  output logic             pumpUp,
  output logic             pumpDown,
  output logic             pumpDrive,
  output logic             lockOut
);
  ctrlStrobeT strobe;

  hpd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .syncIn(syncIn),
    .fbIn  (fbIn),
    .mode  (mode),
    .strobe(strobe)
  );

  hpd_datapath #(
    .OFS_W     (OFS_W),
    .LOCK_LINES(LOCK_LINES),
    .STRETCH   (STRETCH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lockWindow(lockWindow),
    .pumpUp    (pumpUp),
    .pumpDown  (pumpDown),
    .pumpDrive (pumpDrive),
    .lockOut   (lockOut)
  );
endmodule

// File: rtl/hpd_checker.sv
module hpd_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       pumpUp,
  input logic       pumpDown,
  input logic       pumpDrive,
  input logic       lockOut
);
  // R7: enables never drive both directions at once
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpUp && pumpDown));

  // R9: coast floats the pump
  a_r9_coast_no_pump: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 || mode == 2'b11) |-> (!pumpUp && !pumpDown));

  // R9: coast keeps the drive flag low
  a_r9_coast_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 || mode == 2'b11) |-> !pumpDrive);

  // R9: no lock pulse for a comparison made in coast
  a_r9_coast_no_lock_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 || mode == 2'b11) |=> !lockOut);

  // R10: each lock pulse lasts a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    lockOut |=> !lockOut);
endmodule

bind hsync_phase_det hpd_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .pumpUp   (pumpUp),
  .pumpDown (pumpDown),
  .pumpDrive(pumpDrive),
  .lockOut  (lockOut)
);

// File: tb/hsync_phase_det_test.sv
`timescale 1ns/1ps
module hsync_phase_det_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b0;
  logic        fbIn = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [11:0] win = 12'd2;
  logic        pumpUp, pumpDown, pumpDrive, lockOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R2";

  // behavioural model state
  int ms1, ms2, ms3, mf1, mf2, mf3;
  int mUp, mDn, mOfs, mStr, mDir, mGood, mLock;

  always #4 clk = ~clk;

  hsync_phase_det uut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .fbIn(fbIn), .mode(mode),
    .lockWindow(win), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .pumpDrive(pumpDrive), .lockOut(lockOut)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic modelReset();
    ms1 = 0; ms2 = 0; ms3 = 0; mf1 = 0; mf2 = 0; mf3 = 0;
    mUp = 0; mDn = 0; mOfs = 0; mStr = 0; mDir = 0; mGood = 0; mLock = 0;
  endtask

  task automatic modelStep(input int s, input int f);
    int rs, rf, fin, held, ofs;
    bit coast, fast;
    rs = (ms2 != 0 && ms3 == 0) ? 1 : 0;
    rf = (mf2 != 0 && mf3 == 0) ? 1 : 0;
    fin  = ((mUp != 0 || rs != 0) && (mDn != 0 || rf != 0)) ? 1 : 0;
    held = (mUp != 0 || mDn != 0) ? 1 : 0;
    ofs = mOfs + held;
    if (ofs > 4095) ofs = 4095;
    coast = mode[1];
    fast  = (mode == 2'b01);
    if (coast || !fast) mStr = 0;
    else if (fin != 0) begin mStr = 3 * ofs; mDir = mUp; end
    else if (mStr > 0) mStr--;
    if (fin != 0 && !coast) begin
      if (ofs <= int'(win)) mGood = (mGood < 8) ? mGood + 1 : 8;
      else mGood = 0;
      mLock = (mGood != 8) ? 1 : 0;
    end else mLock = 0;
    if (fin != 0) mOfs = 0;
    else if (held != 0) mOfs = (mOfs + 1 > 4095) ? 4095 : mOfs + 1;
    else mOfs = 0;
    if (fin != 0) begin mUp = 0; mDn = 0; end
    else begin
      mUp = (mUp != 0 || rs != 0) ? 1 : 0;
      mDn = (mDn != 0 || rf != 0) ? 1 : 0;
    end
    ms3 = ms2; ms2 = ms1; ms1 = s;
    mf3 = mf2; mf2 = mf1; mf1 = f;
  endtask

  // compare on one negedge, then drive the next inputs and advance the model
  task automatic tick(input logic s, input logic f, output logic gotUp,
                      output logic gotDn, output logic gotLock);
    int eu, ed, raw;
    bit fast, coast;
    @(negedge clk);
    fast  = (mode == 2'b01);
    coast = mode[1];
    raw = (mUp != 0 || mDn != 0) ? 1 : 0;
    eu = (!coast && (mUp != 0 || (raw == 0 && fast && mStr > 0 && mDir != 0))) ? 1 : 0;
    ed = (!coast && (mDn != 0 || (raw == 0 && fast && mStr > 0 && mDir == 0))) ? 1 : 0;
    check(tag, "per-cycle pumpUp", int'(pumpUp), eu);
    check(tag, "per-cycle pumpDown", int'(pumpDown), ed);
    check("R7", "per-cycle pumpDrive", int'(pumpDrive), (eu != 0 || ed != 0) ? 1 : 0);
    check(tag, "per-cycle lockOut", int'(lockOut), mLock);
    gotUp = pumpUp; gotDn = pumpDown; gotLock = lockOut;
    syncIn = s; fbIn = f;
    modelStep(int'(s), int'(f));
  endtask

  // one line: sync rises at sA (and sB if >= 0), feedback rises at fA; pulses 8 wide
  task automatic runLine(input int sA, input int sB, input int fA, input int len,
                         input int expUp, input int expDn, input int expLock,
                         input int expFirstUp, input string req);
    int nu, nd, nl, firstUp;
    logic u, d, l, s, f;
    nu = 0; nd = 0; nl = 0; firstUp = -1;
    tag = req;
    for (int c = 0; c < len; c++) begin
      s = ((c >= sA && c < sA + 8) || (sB >= 0 && c >= sB && c < sB + 8));
      f = (c >= fA && c < fA + 8);
      tick(s, f, u, d, l);
      if (u) begin nu++; if (firstUp < 0) firstUp = c; end
      if (d) nd++;
      if (l) nl++;
    end
    if (expUp >= 0)      check(req, "pumpUp cycles in line", nu, expUp);
    if (expDn >= 0)      check(req, "pumpDown cycles in line", nd, expDn);
    if (expLock >= 0)    check(req, "lockOut pulses in line", nl, expLock);
    if (expFirstUp >= 0) check("R2", "first pumpUp cycle", firstUp, expFirstUp + 1);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    check("R7", "reset pumpUp", int'(pumpUp), 0);
    check("R7", "reset pumpDown", int'(pumpDown), 0);
    check("R7", "reset pumpDrive", int'(pumpDrive), 0);
    check("R10", "reset lockOut", int'(lockOut), 0);
    rstN = 1'b1;
    modelStep(0, 0);

    // normal tracking, window 2
    runLine(5, -1, 10, 60, 5, 0, 1, 7, "R3");   // sync leads by 5; first up at tick 5+3 (sampled one later)
    runLine(12, -1, 6, 60, 0, 6, 1, -1, "R4");  // feedback leads by 6
    runLine(8, -1, 8, 60, 0, 0, 1, -1, "R5");   // coincident edges, in window but not yet locked
    runLine(2, 20, 40, 80, 38, 0, 1, -1, "R6"); // repeated sync edge before feedback
    mode = 2'b01;
    runLine(5, -1, 10, 60, 20, 0, 1, -1, "R8"); // fast-lock stretch 4*5
    runLine(10, -1, 7, 60, 0, 12, 1, -1, "R8"); // fast-lock stretch 4*3 down
    mode = 2'b00;

    // acquire lock: window 3, offset 2
    win = 12'd3;
    for (int i = 0; i < 8; i++)
      runLine(5, -1, 7, 60, 2, 0, (i < 7) ? 1 : 0, -1, "R10");
    runLine(5, -1, 8, 60, 3, 0, 0, -1, "R10");  // offset equal to window stays locked

    // coast: both codes, large error, no pump and no pulse
    mode = 2'b10;
    runLine(5, -1, 15, 60, 0, 0, 0, -1, "R9");
    mode = 2'b11;
    runLine(15, -1, 5, 60, 0, 0, 0, -1, "R1");
    mode = 2'b00;
    runLine(5, -1, 6, 60, 1, 0, 0, -1, "R9");   // lock kept through coast

    // single bad line drops lock and restarts the count
    runLine(5, -1, 14, 60, 9, 0, 1, -1, "R11");
    runLine(5, -1, 6, 60, 1, 0, 1, -1, "R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule